// File: doc/BRIEF.md
# Base Address Window Decoder

This block keeps the base address registers of one configuration function: six general regions and one expansion-ROM region. It also keeps the two command bits that switch decoding on. Software programs a region by writing a full 32-bit word to the region's configuration slot. The block clears the bits below the region's natural size, so the stored base is always size-aligned. For the ROM slot, the enable flag in bit 0 is kept.

From the stored bases and the command bits, the block works out a decode window for every region. A window has a start, an inclusive end and a validity flag. A window is valid only if all of the following hold:

- the matching command bit is set;
- the base is nonzero;
- the window does not run past the top of the address space;
- for an I/O region, the window stays inside the 64 KiB port space.

An incoming access carries an address and a space flag (I/O or memory). It raises the hit line of every valid region of that space whose window holds the address. Region sizes and region types are elaboration parameters.

Top module: `bar_decode_unit`

## Requirements
- R1: After reset every stored base and both command bits are zero, and no region is active or hit.
- R2: A write with all four byte enables set, to word 4+i (byte offset 0x10+4i) for region i in 0..5, stores the write data with bits below the region size cleared.
- R3: A full write to word 12 (byte offset 0x30) stores the ROM base with bits below the ROM size cleared except bit 0. The ROM window is active only while that stored bit 0 is 1.
- R4: A write to a base slot with any byte enable clear leaves the stored base unchanged.
- R5: The command register is word 1 (offset 0x04). A write with byte enable 0 set loads bit 0 (I/O decode enable) and bit 1 (memory decode enable). I/O regions are active only while bit 0 is 1, and memory regions and the ROM only while bit 1 is 1.
- R6: A region is inactive if its masked base is zero or if its size parameter is zero.
- R7: An I/O window is inactive if its last address (base + size - 1) is 0x10000 or above or wraps. A memory window is inactive if its last address wraps past 0xFFFFFFFF.
- R8: region_active reflects a configuration write, including a command write, after two rising clock edges. region_hit is registered and reflects an access one rising edge after it is presented.
- R9: region_hit[i] is 1 only if acc_valid is 1, acc_is_io equals the region's type (1 = I/O), region i is active, and start <= acc_addr <= start + size - 1.
- R10: cfg_rdata returns, one edge after cfg_rd_word is presented, the stored base for base slots, {30'b0, command bits} for word 1, and zero for other words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_word | input | 6 | Configuration write word index (byte offset / 4) |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_word | input | 6 | Configuration read word index |
| cfg_rdata | output | 32 | Registered read data |
| acc_valid | input | 1 | Access address valid |
| acc_is_io | input | 1 | Access space: 1 = I/O, 0 = memory |
| acc_addr | input | 32 | Access address |
| region_active | output | NUM_BARS+1 | Per-region window valid; top bit is the ROM |
| region_hit | output | NUM_BARS+1 | Per-region registered hit; top bit is the ROM |

## Verification
The bench uses the default parameters. These make regions 0, 2 and 4 I/O regions of 16, 256 and 4 bytes. Regions 1 and 3 are memory regions of 4 KiB and 1 MiB, region 5 has size zero, and the ROM is 64 KiB. This mix brings within reach several cases that a single size would not cover:
- the smallest I/O window ending exactly at 0xFFFF;
- an I/O base just over the 64 KiB limit;
- an unused region whose size is zero;
- a ROM whose enable bit must survive the masking.

It also lets one address table show that space matching and inclusive end points hold in both spaces at once.

// File: rtl/bar_pkg.sv
package bar_pkg;

  localparam logic [5:0] CMD_WORD = 6'd1;
  localparam logic [5:0] BAR_WORD0 = 6'd4;
  localparam logic [5:0] ROM_WORD = 6'd12;

  function automatic logic [5:0] slot_word(input int idx, input int nbars);
    if (idx == nbars) return ROM_WORD;
    return BAR_WORD0 + 6'(idx);
  endfunction

  typedef struct packed {
    logic [31:0] first;
    logic [31:0] last;
    logic        valid;
  } window_t;

endpackage

// File: rtl/bar_cfg_store.sv
module bar_cfg_store
  import bar_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS:0][31:0] SIZES = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [5:0]                wr_word,
  input  logic [3:0]                be,
  input  logic [31:0]               wdata,
  input  logic [5:0]                rd_word,
  output logic [31:0]               rdata,
  output logic [NUM_BARS:0][31:0]   base_q,
  output logic                      io_en_q,
  output logic                      mem_en_q
);

  localparam int NREG = NUM_BARS + 1;

  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (rd_word == CMD_WORD) rd_mux = {30'd0, mem_en_q, io_en_q};
    for (int i = 0; i < NREG; i++) begin
      if (rd_word == slot_word(i, NUM_BARS)) rd_mux = base_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      io_en_q  <= 1'b0;
      mem_en_q <= 1'b0;
      rdata    <= '0;
    end else begin
      rdata <= rd_mux;
      if (wr_en) begin
        if (wr_word == CMD_WORD && be[0]) begin
          io_en_q  <= wdata[0];
          mem_en_q <= wdata[1];
        end
        if (be == 4'hF) begin
          for (int i = 0; i < NREG; i++) begin
            if (wr_word == slot_word(i, NUM_BARS)) begin
              if (i == NUM_BARS)
                base_q[i] <= wdata & (~(SIZES[i] - 32'd1) | 32'd1);
              else
                base_q[i] <= wdata & ~(SIZES[i] - 32'd1);
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/bar_window_eval.sv
module bar_window_eval
  import bar_pkg::*;
#(
  parameter logic [31:0] SIZE   = 32'h10,
  parameter bit          IS_IO  = 1'b0,
  parameter bit          IS_ROM = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] base,
  input  logic        io_en,
  input  logic        mem_en,
  output window_t     win
);

  localparam logic [32:0] IO_LIMIT = 33'h1_0000;

  logic [31:0] start;
  logic [32:0] last_ext;
  logic        space_en;
  logic        rom_ok;
  logic        range_ok;

  always_comb begin
    start    = base & ~(SIZE - 32'd1);
    last_ext = {1'b0, start} + {1'b0, SIZE} - 33'd1;
    space_en = IS_IO ? io_en : mem_en;
    rom_ok   = IS_ROM ? base[0] : 1'b1;
    if (IS_IO)
      range_ok = !last_ext[32] && (last_ext < IO_LIMIT) && (last_ext[31:0] > start);
    else
      range_ok = !last_ext[32] && (last_ext[31:0] > start);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win <= '0;
    end else begin
      win.first <= start;
      win.last  <= last_ext[31:0];
      win.valid <= space_en && rom_ok && range_ok && (SIZE != 32'd0) && (start != 32'd0);
    end
  end

endmodule

// File: rtl/bar_hit_match.sv
module bar_hit_match
  import bar_pkg::*;
#(
  parameter bit IS_IO = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  window_t     win,
  input  logic        acc_valid,
  input  logic        acc_is_io,
  input  logic [31:0] acc_addr,
  output logic        hit
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
    end else begin
      hit <= acc_valid && (acc_is_io == IS_IO) && win.valid &&
             (acc_addr >= win.first) && (acc_addr <= win.last);
    end
  end

endmodule

// File: rtl/bar_decode_unit.sv
module bar_decode_unit
  import bar_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS:0][31:0] REGION_SIZE = {
    32'h0001_0000, 32'h0, 32'h4, 32'h0010_0000, 32'h100, 32'h1000, 32'h10},
  parameter logic [NUM_BARS-1:0] REGION_IS_IO = 6'b010101
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr_en,
  input  logic [5:0]           cfg_wr_word,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  input  logic [5:0]           cfg_rd_word,
  output logic [31:0]          cfg_rdata,
  input  logic                 acc_valid,
  input  logic                 acc_is_io,
  input  logic [31:0]          acc_addr,
  output logic [NUM_BARS:0]    region_active,
  output logic [NUM_BARS:0]    region_hit
);

  localparam int NREG = NUM_BARS + 1;

  logic [NUM_BARS:0][31:0] base_q;
  logic                    io_en_q;
  logic                    mem_en_q;
  window_t                 win [NREG];

  bar_cfg_store #(.NUM_BARS(NUM_BARS), .SIZES(REGION_SIZE)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr_en),
    .wr_word  (cfg_wr_word),
    .be       (cfg_be),
    .wdata    (cfg_wdata),
    .rd_word  (cfg_rd_word),
    .rdata    (cfg_rdata),
    .base_q   (base_q),
    .io_en_q  (io_en_q),
    .mem_en_q (mem_en_q)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_region
    localparam bit G_ROM = (g == NUM_BARS);
    localparam bit G_IO  = G_ROM ? 1'b0 : REGION_IS_IO[g];

    bar_window_eval #(.SIZE(REGION_SIZE[g]), .IS_IO(G_IO), .IS_ROM(G_ROM)) u_win (
      .clk    (clk),
      .rst    (rst),
      .base   (base_q[g]),
      .io_en  (io_en_q),
      .mem_en (mem_en_q),
      .win    (win[g])
    );

    bar_hit_match #(.IS_IO(G_IO)) u_hit (
      .clk       (clk),
      .rst       (rst),
      .win       (win[g]),
      .acc_valid (acc_valid),
      .acc_is_io (acc_is_io),
      .acc_addr  (acc_addr),
      .hit       (region_hit[g])
    );

    assign region_active[g] = win[g].valid;
  end

endmodule

// File: rtl/bar_decode_chk.sv
module bar_decode_chk #(
  parameter int NREG = 7,
  parameter logic [NREG-1:0] IO_MASK = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_wr_en,
  input logic [5:0]      cfg_wr_word,
  input logic [3:0]      cfg_be,
  input logic [31:0]     base0,
  input logic            io_en,
  input logic            mem_en,
  input logic            acc_valid,
  input logic            acc_is_io,
  input logic [NREG-1:0] region_active,
  input logic [NREG-1:0] region_hit
);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (region_active == '0 && region_hit == '0));

  p_partial_write_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_wr_word == 6'd4 && cfg_be != 4'hF) |=> $stable(base0));

  p_io_needs_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    ((region_active & IO_MASK) != '0) |-> $past(io_en));

  p_mem_needs_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    ((region_active & ~IO_MASK) != '0) |-> $past(mem_en));

  p_hit_needs_active_r9: assert property (@(posedge clk) disable iff (rst)
    (region_hit != '0) |-> (((region_hit & ~$past(region_active)) == '0) && $past(acc_valid)));

  p_hit_space_r9: assert property (@(posedge clk) disable iff (rst)
    ((region_hit & IO_MASK) != '0) |-> $past(acc_is_io));

endmodule

bind bar_decode_unit bar_decode_chk #(.NREG(NUM_BARS + 1), .IO_MASK({1'b0, REGION_IS_IO})) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_wr_en     (cfg_wr_en),
  .cfg_wr_word   (cfg_wr_word),
  .cfg_be        (cfg_be),
  .base0         (base_q[0]),
  .io_en         (io_en_q),
  .mem_en        (mem_en_q),
  .acc_valid     (acc_valid),
  .acc_is_io     (acc_is_io),
  .region_active (region_active),
  .region_hit    (region_hit)
);

// File: tb/sim_bar_decode_unit.sv
`timescale 1ns/1ps
module sim_bar_decode_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [5:0]  cfg_wr_word = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  cfg_rd_word = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_is_io = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [6:0]  region_active;
  logic [6:0]  region_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bar_decode_unit u0 (.*);

  // {is_io, address, expected hit vector}
  localparam logic [39:0] VEC [12] = '{
    {1'b1, 32'h0000_01F0, 7'b0000001},
    {1'b1, 32'h0000_01FF, 7'b0000001},
    {1'b1, 32'h0000_0200, 7'b0000000},
    {1'b0, 32'h0000_01F0, 7'b0000000},
    {1'b0, 32'hE000_0FFF, 7'b0000010},
    {1'b0, 32'hE000_1000, 7'b0000000},
    {1'b1, 32'h0000_C0FF, 7'b0000100},
    {1'b0, 32'hF00F_FFFF, 7'b0001000},
    {1'b0, 32'hF010_0000, 7'b1000000},
    {1'b1, 32'h0000_FFFD, 7'b0010000},
    {1'b0, 32'hF010_FFFF, 7'b1000000},
    {1'b0, 32'hF011_0000, 7'b0000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] w, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_word = w; cfg_be = b; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] w, output logic [31:0] d);
    @(negedge clk);
    cfg_rd_word = w;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic probe(input logic io, input logic [31:0] a, output logic [6:0] h);
    @(negedge clk);
    acc_valid = 1'b1; acc_is_io = io; acc_addr = a;
    @(negedge clk);
    h = region_hit;
    acc_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    logic [6:0]  h;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 active", 32'(region_active), 32'h0);
    check("R1 hit", 32'(region_hit), 32'h0);
    rd(6'd4, d); check("R1 base0", d, 32'h0);
    rd(6'd1, d); check("R1 cmd", d, 32'h0);

    // R2 masking, R4 partial write ignored
    wr(6'd4, 4'hF, 32'h0000_01F7);
    rd(6'd4, d); check("R2 base0 masked", d, 32'h0000_01F0);
    wr(6'd4, 4'h3, 32'h0000_0330);
    rd(6'd4, d); check("R4 partial ignored", d, 32'h0000_01F0);
    wr(6'd5, 4'hF, 32'hE000_0ABC);
    rd(6'd5, d); check("R2 base1 masked", d, 32'hE000_0000);
    // R3 ROM keeps bit 0
    wr(6'd12, 4'hF, 32'hF010_ABCD);
    rd(6'd12, d); check("R3 rom stored", d, 32'hF010_0001);
    wr(6'd6, 4'hF, 32'h0000_C0AB);
    wr(6'd7, 4'hF, 32'hF000_0000);
    wr(6'd8, 4'hF, 32'h0000_FFFC);
    wr(6'd9, 4'hF, 32'h1234_5678);
    rd(6'd20, d); check("R10 unmapped word", d, 32'h0);

    // R5: no decode before command
    @(negedge clk);
    check("R5 cmd off", 32'(region_active), 32'h0);
    wr(6'd1, 4'h1, 32'h1);
    @(negedge clk);
    check("R5 io only", 32'(region_active), 32'b0010101);
    wr(6'd1, 4'h2, 32'h0);
    rd(6'd1, d); check("R5 be0 clear ignored", d, 32'h1);
    wr(6'd1, 4'h1, 32'h3);
    @(negedge clk);
    // R6 region 5 size zero stays inactive
    check("R6 R8 all but size-zero", 32'(region_active), 32'b1011111);

    // R9 table of accesses
    for (int k = 0; k < 12; k++) begin
      probe(VEC[k][39], VEC[k][38:7], h);
      check($sformatf("R9 vector %0d", k), 32'(h), 32'(VEC[k][6:0]));
    end
    // R9 valid low gives no hit
    @(negedge clk);
    acc_valid = 1'b0; acc_is_io = 1'b1; acc_addr = 32'h1F4;
    @(negedge clk);
    check("R9 no valid", 32'(region_hit), 32'h0);

    // R8 timing: one edge after a write, active not yet changed
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_word = 6'd4; cfg_be = 4'hF; cfg_wdata = 32'h0001_0000;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check("R8 not yet", 32'(region_active[0]), 32'h1);
    @(negedge clk);
    // R7 I/O above 64K
    check("R7 io above 64K", 32'(region_active[0]), 32'h0);
    // R6 zero base
    wr(6'd6, 4'hF, 32'h0000_0000);
    @(negedge clk);
    check("R6 zero base", 32'(region_active[2]), 32'h0);
    // R3 ROM enable cleared
    wr(6'd12, 4'hF, 32'hF010_0000);
    @(negedge clk);
    check("R3 rom disabled", 32'(region_active[6]), 32'h0);
    // R5 memory disabled by command
    wr(6'd1, 4'h1, 32'h1);
    @(negedge clk);
    check("R5 mem off", 32'(region_active & 7'b0001010), 32'h0);
    check("R5 io kept", 32'(region_active[4]), 32'h1);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule